// File: doc/BRIEF.md
# Pipelined Burst SRAM Model

A synthesizable single-clock SRAM with a burst address sequencer, a one-stage read pipeline and per-byte write masking. Every control, address and data input is taken on the rising clock edge. An access starts when one of two address strobes loads an external address. The two strobes qualify the chip enables differently. The processor strobe is honoured only when the primary enable is active, and it always performs a read. The controller strobe needs all three enables, and it may read or write.

After a load, the low two address bits come from a two-bit beat counter. The counter steps in linear or interleaved order, and the order is captured together with the address. An advance input steps the counter. Holding the advance input inactive repeats the current address as a wait state.

Read data passes through one output register and leaves as a value with a valid flag. An asynchronous output enable gates that pair without touching the pipeline.

Top module: `pbs_sram`

## Requirements
- R1: A read access decided at rising edge k shows on `rd_data` with `rd_valid` high after edge k+1, provided `oe_n` is low. Write cycles and idle cycles leave `rd_valid` low.
- R2: With `burst_il` low at load, beat n (counted 0..3, modulo 4) addresses low bits (loaded low bits + n) mod 4. The upper address bits never change during a burst.
- R3: With `burst_il` high at load, beat n addresses low bits (loaded low bits XOR n). The order is taken only at load, so changing `burst_il` mid-burst has no effect.
- R4: `adsp_n` low with `ce_n` low aborts any burst and loads `addr`. It is a read whatever `gw_n`, `bwe_n`, `bw_n` and `adsc_n` are doing, and memory is left unchanged.
- R5: While `ce_n` is high, `adsp_n` is ignored. The cycle behaves as an `adsc_n` cycle or as a continuation beat, depending on the other inputs.
- R6: `adsc_n` low, when the processor strobe does not take effect, loads `addr` if `ce_n` is low, `ce2` is high and `ce2_n` is low. The access is a write if any write enable is active, and a read otherwise.
- R7: A load with `ce2` low or `ce2_n` high (or, for `adsc_n`, `ce_n` high) deselects. No access takes place, `rd_valid` is low after one pipeline cycle, and continuation beats do nothing until the next selected load.
- R8: The chip enables are not looked at on continuation beats.
- R9: On a continuation beat of an active burst, `adv_n` low steps the beat counter. `adv_n` high repeats the same address.
- R10: `gw_n` low writes all four byte lanes, regardless of `bwe_n` and `bw_n`.
- R11: With `gw_n` high, lane i (bits 8i+7..8i) is written only when `bwe_n` is low and `bw_n[i]` is low. With no write enable active, an access is a read.
- R12: `oe_n` high forces `rd_valid` low and `rd_data` to zero at once. It has no effect on memory or on the pipeline.
- R13: After reset, `rd_valid` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 6 | External word address |
| wdata | input | 32 | Write data, four byte lanes |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Expansion chip enable, active high |
| ce2_n | input | 1 | Expansion chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global full-width write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | 4 | Per-lane write selects, active low |
| burst_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rd_data | output | 32 | Read data, zero when not valid |
| rd_valid | output | 1 | Read data valid |

## Verification
The bench goes after several corner cases, each with a distinct failure.
- Burst order: every start address is swept in both orders. A sequencer that carried into the upper bits, or ignored the captured order, returns data from the wrong word.
- Processor strobe: it is issued with global write active. A design that let it write would corrupt memory, and it is also issued with `ce_n` high, where a design that obeyed it would restart the burst.
- Chip enables: deselecting loads are followed by advance beats that must stay silent. Enables driven inactive during a running burst must not stop it.
- Byte lanes: all sixteen byte-lane masks are written and read back. A lane decode error shows up as a stale byte.
- Pseudo-random mix: a long mixed sequence catches ordering slips between writes and following reads.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/pbs_burst_seq.sv
module pbs_burst_seq
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce2_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              burst_il,
    output op_e               op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LANES-1:0]  mask_o
);
    localparam int BEAT_W = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] cnt;
        logic              il;
        logic              act;
    } seq_t;

    seq_t seq_d, seq_q;
    logic p_go, c_go, sel_x, wr_any;
    logic [LANES-1:0]  mask_w;
    logic [BEAT_W-1:0] low_w;

    always_comb begin
        seq_d  = seq_q;
        op_o   = OP_NONE;
        addr_o = addr;
        p_go   = !adsp_n && !ce_n;
        c_go   = !adsc_n && !p_go;
        sel_x  = ce2 && !ce2_n;
        mask_w = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : '0);
        wr_any = |mask_w;
        low_w  = '0;
        if (p_go || c_go) begin
            seq_d.base = addr;
            seq_d.cnt  = '0;
            seq_d.il   = burst_il;
            seq_d.act  = sel_x && !ce_n;
            if (seq_d.act) begin
                op_o = (p_go || !wr_any) ? OP_READ : OP_WRITE;
            end
        end else if (seq_q.act) begin
            if (!adv_n) begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
            low_w  = seq_q.il ? (seq_q.base[BEAT_W-1:0] ^ seq_d.cnt)
                              : (seq_q.base[BEAT_W-1:0] + seq_d.cnt);
            addr_o = {seq_q.base[ADDR_W-1:BEAT_W], low_w};
            op_o   = wr_any ? OP_WRITE : OP_READ;
        end
        mask_o = (op_o == OP_WRITE) ? mask_w : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R4: processor strobe with primary enable never writes
    a_r4_adsp_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce_n) |-> (op_o != OP_WRITE));

    // R5: ignored processor strobe with no controller strobe keeps a burst alive
    a_r5_adsp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !adsp_n && adsc_n && seq_q.act) |=> seq_q.act);

    // R9: a wait beat keeps the beat counter
    a_r9_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.act && adsp_n && adsc_n && adv_n) |=> $stable(seq_q.cnt));
endmodule

// File: rtl/pbs_byte_ram.sv
module pbs_byte_ram
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  op_e                     op,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] data_q,
    output logic                    valid_q
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } out_t;

    out_t out_d, out_q;
    logic [LANE_W-1:0] lane_rd [LANES];
    logic [DATA_W-1:0] word_rd;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (op == OP_WRITE && mask[l]) begin
                mem[addr] <= wdata[l*LANE_W +: LANE_W];
            end
        end
        assign lane_rd[l] = mem[addr];
        assign word_rd[l*LANE_W +: LANE_W] = lane_rd[l];
    end

    always_comb begin
        out_d       = out_q;
        out_d.valid = (op == OP_READ);
        if (op == OP_READ) begin
            out_d.data = word_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign data_q  = out_q.data;
    assign valid_q = out_q.valid;

    // R1: valid output only follows a read access
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_READ) |=> !valid_q);
endmodule

// File: rtl/pbs_sram.sv
module pbs_sram
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    ce_n,
    input  logic                    ce2,
    input  logic                    ce2_n,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    burst_il,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_valid
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  mask;
        logic [DATA_W-1:0] wd;
    } stg_t;

    stg_t stg_d, stg_q;
    op_e               op_c;
    logic [ADDR_W-1:0] addr_c;
    logic [LANES-1:0]  mask_c;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;

    pbs_burst_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) seq_i (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .burst_il(burst_il),
        .op_o(op_c), .addr_o(addr_c), .mask_o(mask_c)
    );

    always_comb begin
        stg_d      = stg_q;
        stg_d.op   = op_c;
        stg_d.addr = addr_c;
        stg_d.mask = mask_c;
        stg_d.wd   = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    pbs_byte_ram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) ram_i (
        .clk(clk), .rst_n(rst_n), .op(stg_q.op), .addr(stg_q.addr),
        .mask(stg_q.mask), .wdata(stg_q.wd),
        .data_q(data_q), .valid_q(valid_q)
    );

    assign rd_valid = valid_q && !oe_n;
    assign rd_data  = rd_valid ? data_q : '0;

    // R1: a read decided now is visible one pipeline cycle later
    a_r1_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (op_c == OP_READ) |=> ##1 (rd_valid || oe_n));

    // R7: a cycle with no access yields no valid data
    a_r7_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_c == OP_NONE) |=> ##1 !rd_valid);
endmodule

// File: tb/pbs_sram_tb.sv
`timescale 1ns/1ps
module pbs_sram_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic        ce_n, ce2, ce2_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, burst_il, oe_n;
    logic [3:0]  bw_n;
    logic [31:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int errors = 0;

    // bench reference state
    logic [31:0] m_mem [64];
    logic [5:0]  m_base;
    logic [1:0]  m_cnt;
    logic        m_il, m_act;
    int          p_op;          // 0 none, 1 read, 2 write
    logic [5:0]  p_addr;
    logic [3:0]  p_mask;
    logic [31:0] p_wd;
    logic        e_v;
    logic [31:0] e_d;
    logic [31:0] lfsr = 32'h1234_5678;

    always #4 clk = ~clk;

    pbs_sram dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .burst_il(burst_il), .oe_n(oe_n), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [31:0] pat(input int a);
        return 32'h9E37_79B9 * (a + 7);
    endfunction

    task automatic idle_in();
        addr = '0; wdata = '0; ce_n = 1'b0; ce2 = 1'b1; ce2_n = 1'b0;
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1;
        bw_n = 4'hF; burst_il = 1'b0; oe_n = 1'b0;
    endtask

    task automatic model_edge();
        logic p_go, c_go, sel;
        logic [3:0] mk;
        logic [1:0] lo;
        // output stage
        e_v = (p_op == 1);
        if (p_op == 1) e_d = m_mem[p_addr];
        if (p_op == 2) begin
            for (int l = 0; l < 4; l++)
                if (p_mask[l]) m_mem[p_addr][l*8 +: 8] = p_wd[l*8 +: 8];
        end
        // decode
        p_go = !adsp_n && !ce_n;
        c_go = !adsc_n && !p_go;
        sel  = ce2 && !ce2_n;
        mk   = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
        p_op = 0; p_wd = wdata; p_mask = mk;
        if (p_go) begin
            m_base = addr; m_cnt = 0; m_il = burst_il; m_act = sel;
            if (sel) begin p_op = 1; p_addr = addr; end
        end else if (c_go) begin
            m_base = addr; m_cnt = 0; m_il = burst_il; m_act = sel && !ce_n;
            if (m_act) begin p_op = (mk != 0) ? 2 : 1; p_addr = addr; end
        end else if (m_act) begin
            if (!adv_n) m_cnt = m_cnt + 2'd1;
            lo = m_il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
            p_addr = {m_base[5:2], lo};
            p_op = (mk != 0) ? 2 : 1;
        end
    endtask

    task automatic check(input string tag);
        logic        xv;
        logic [31:0] xd;
        xv = e_v && !oe_n;
        xd = xv ? e_d : 32'h0;
        checks++;
        if (rd_valid !== xv || rd_data !== xd) begin
            errors++;
            $display("FAIL %s actual valid=%b data=%h expected valid=%b data=%h",
                     tag, rd_valid, rd_data, xv, xd);
        end
    endtask

    // one clock: inputs already set; model the edge, then sample at the falling edge
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic flush(input string tag);
        idle_in();
        step(tag);
        step(tag);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_in();
        p_op = 0; m_act = 0; m_cnt = 0; m_base = 0; m_il = 0; e_v = 0; e_d = 0;
        p_addr = 0; p_mask = 0; p_wd = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R13 reset");

        // fill all words: controller strobe with global write, linear beats (R6, R10, R2)
        for (int b = 0; b < 64; b += 4) begin
            idle_in(); adsc_n = 0; gw_n = 0; bwe_n = 1; addr = b[5:0]; wdata = pat(b);
            step("R6 fill");
            for (int k = 1; k < 4; k++) begin
                idle_in(); adv_n = 0; gw_n = 0; wdata = pat(b + k);
                step("R10 fill");
            end
        end
        flush("R1 flush");

        // read bursts from every start in both orders (R1, R2, R3, R4)
        for (int md = 0; md < 2; md++) begin
            for (int a = 0; a < 64; a++) begin
                idle_in(); adsp_n = 0; addr = a[5:0]; burst_il = md[0];
                step("R4 read start");
                for (int k = 1; k < 4; k++) begin
                    idle_in(); adv_n = 0; burst_il = ~md[0];
                    step(md == 0 ? "R2 linear beat" : "R3 interleaved beat");
                end
            end
        end
        flush("R1 flush");

        // wait states (R9)
        idle_in(); adsp_n = 0; addr = 6'd13; burst_il = 1;
        step("R9 start");
        for (int k = 0; k < 8; k++) begin
            idle_in(); adv_n = (k % 3 != 1);
            step("R9 wait/advance");
        end
        flush("R9 flush");

        // byte lanes, all masks (R11) and global write over disabled bytes (R10)
        for (int m = 0; m < 16; m++) begin
            idle_in(); adsc_n = 0; bwe_n = 0; bw_n = ~m[3:0]; addr = 6'd40;
            wdata = 32'hC3C3_0000 | m * 32'h0101_0101;
            step("R11 byte write");
            idle_in(); adsp_n = 0; addr = 6'd40;
            step("R11 readback");
            step("R11 readback data");
        end
        idle_in(); adsc_n = 0; bwe_n = 1; bw_n = 4'h0; addr = 6'd41; wdata = 32'hDEAD_BEEF;
        step("R11 no bwe is read");
        step("R11 no bwe data");
        idle_in(); adsc_n = 0; gw_n = 0; bwe_n = 1; bw_n = 4'hF; addr = 6'd42; wdata = 32'h1357_9BDF;
        step("R10 gw write");
        idle_in(); adsp_n = 0; addr = 6'd42;
        step("R10 readback");
        step("R10 readback data");

        // processor strobe aborts with write enables active: still a read (R4)
        idle_in(); adsc_n = 0; addr = 6'd20;
        step("R4 burst");
        idle_in(); adv_n = 0;
        step("R4 beat");
        idle_in(); adsp_n = 0; gw_n = 0; adsc_n = 0; addr = 6'd50; wdata = 32'h0BAD_0BAD;
        step("R4 abort read");
        idle_in(); adsp_n = 0; addr = 6'd50;
        step("R4 memory kept");
        step("R4 memory kept data");

        // processor strobe ignored with ce_n high (R5)
        idle_in(); adsp_n = 0; addr = 6'd8;
        step("R5 start");
        idle_in(); adsp_n = 0; ce_n = 1; adv_n = 0; addr = 6'd60;
        step("R5 ignored beat");
        step("R5 ignored beat 2");
        idle_in(); adsp_n = 0; ce_n = 1; adsc_n = 0; addr = 6'd60;
        step("R5 becomes controller deselect");
        idle_in(); adv_n = 0;
        step("R7 after deselect");
        step("R7 after deselect 2");

        // deselect on expansion enables (R7)
        for (int v = 0; v < 2; v++) begin
            idle_in(); adsp_n = 0; addr = 6'd4;
            if (v == 0) ce2 = 0; else ce2_n = 1;
            step("R7 deselect load");
            for (int k = 0; k < 3; k++) begin
                idle_in(); adv_n = 0;
                step("R7 silent beat");
            end
        end

        // enables ignored on continuation (R8)
        idle_in(); adsc_n = 0; addr = 6'd30; burst_il = 1;
        step("R8 start");
        for (int k = 0; k < 3; k++) begin
            idle_in(); adv_n = 0; ce_n = 1; ce2 = 0; ce2_n = 1;
            step("R8 beat");
        end
        flush("R8 flush");

        // output enable gating (R12)
        idle_in(); adsp_n = 0; addr = 6'd2;
        step("R12 start");
        idle_in(); adv_n = 0; oe_n = 1;
        step("R12 gated");
        idle_in(); adv_n = 0;
        step("R12 ungated");
        idle_in(); oe_n = 1;
        step("R12 gated hold");
        flush("R12 flush");

        // pseudo-random mix (all)
        for (int i = 0; i < 4000; i++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            addr = lfsr[5:0]; wdata = pat(i) ^ lfsr;
            adsp_n = lfsr[6] | lfsr[7]; adsc_n = lfsr[8] | lfsr[9];
            adv_n = lfsr[10]; ce_n = lfsr[11] & lfsr[12]; ce2 = lfsr[13] | lfsr[14];
            ce2_n = lfsr[15] & lfsr[16]; gw_n = lfsr[17] | lfsr[18]; bwe_n = lfsr[19];
            bw_n = lfsr[23:20]; burst_il = lfsr[24]; oe_n = lfsr[25] & lfsr[26];
            step("R1 mix");
        end
        flush("R1 flush");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule